// File: doc/BRIEF.md
# Network Interface Packetizer

This block sits between a processor or memory that uses plain register reads and writes, and one port of an on-chip network router. The IP side writes a descriptor word and then the payload words of a packet into a small input queue. A packer takes them from the queue and sends them to the router as a stream of flits. A packet whose payload fits in one word goes out as a single combined flit. A longer packet goes out as a header flit, then middle flits, then a closing flit. Any bytes of the last flit that lie past the payload size are sent as zero.

In the other direction, flits from the router are unpacked into an output queue. Each header flit adds a descriptor word in front of its payload word. The IP drains the output queue through a read port. Two configuration bits decide whether packet arrival raises an interrupt, and whether a full input queue drives a suspend line back to the IP.

Both flit streams use valid/ready. A flit moves only on a clock edge where valid and ready are both high. Once the sender raises valid, it must keep valid high and keep the flit unchanged until that edge. The receiver may hold ready low for any length of time. The register port has no handshake: a write or read completes in the cycle it is presented, and read data is combinational.

Top module: `ni_packetizer`

## Requirements
- R1: Registers are decoded from `reg_addr`, and an address with nonzero bits [1:0] selects nothing. Address 0x0 is the input queue (write only; reads return 0). Address 0x4 is the output queue (read pops). Address 0x8 is status. Address 0xC is configuration: bit 0 enables the interrupt, bit 1 enables suspend, and reads return the stored bits.
- R2: A descriptor written to 0x0 holds size in bytes in bits [7:0], destination x in [13:11], destination y in [10:8], priority in [15:14] and virtual channel in [17:16]. A size from 0 to 4 yields one flit of kind 2'b11. With size 0, no payload word is taken from the queue and the flit data is zero.
- R3: A size above 4 yields ceil(size/4) flits, each taking one payload word. The first flit has kind 2'b01, the middle flits 2'b00 and the last flit 2'b10.
- R4: A flit is {kind[57:56], vc[55:54], src_x[53:51], src_y[50:48], dst_x[47:45], dst_y[44:42], prio[41:40], size[39:32], data[31:0]}. The source comes from `node_x`/`node_y`. The header fields (bits [53:32]) are zero in flits of kind 2'b00 and 2'b10.
- R5: In the last flit of a packet, data byte i (bits [8i+7:8i]) is forced to zero when size mod 4 is nonzero and i is greater than or equal to size mod 4.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_flit` does not change.
- R7: A write to 0x0 while the input queue holds 8 words is dropped and leaves the queue contents unchanged.
- R8: `suspend` is high exactly when configuration bit 1 is set and the input queue holds 8 words.
- R9: An accepted flit of kind 2'b01 or 2'b11 pushes a descriptor word, then its data word. The descriptor holds size in [7:0], source {x,y} in [13:8], priority in [15:14], vc in [17:16] and destination {x,y} in [23:18]. Flits of kind 2'b00 or 2'b10 push only their data word.
- R10: A read of 0x4 returns the oldest output word and removes it. When the output queue is empty, the read returns 0 and removes nothing.
- R11: `rx_ready` is low while the output queue holds 8 words, and while a header's data word is still waiting to be pushed.
- R12: Accepting a header flit sets an arrival flag. A write to 0x8 clears it. `irq` equals the flag ANDed with configuration bit 0.
- R13: Status reads return: bit 0 input full, bit 1 input empty, bit 2 output full, bit 3 output empty, bit 4 arrival flag, and bits [15:8] the low data byte of the last header received, which carries the packet type (1 read request, 2 read response, 3 write request, 4 write response, 5 synchronisation). After reset the status reads 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | 3 | X coordinate of this node |
| node_y | input | 3 | Y coordinate of this node |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Packet arrival interrupt |
| suspend | output | 1 | Tells the IP to stop writing |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Router accepts outgoing flit |
| tx_flit | output | 58 | Outgoing flit |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Block accepts incoming flit |
| rx_flit | input | 58 | Incoming flit |

## Verification
The assertions assume the IP follows every descriptor with exactly ceil(size/4) payload words. They also assume that incoming flits arrive in legal packet order, and that the router holds each incoming flit steady while it waits for `rx_ready`. The arrival flag gives priority to a new arrival over a clear, so a status write in the same cycle as a header arrival is not covered. The stimulus writes whole packets, builds incoming packets only from legal kind sequences, and clears the flag only while no flit is being offered. The outgoing ready line follows an irregular pattern and is sometimes held low for long stretches, so stalls occur at first, middle and last flits.

// File: rtl/ni_pkg.sv
package ni_pkg;

  typedef enum logic [1:0] {
    FK_MID   = 2'b00,
    FK_HEAD  = 2'b01,
    FK_TAIL  = 2'b10,
    FK_SOLO  = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    RS_TXQ  = 2'd0,
    RS_RXQ  = 2'd1,
    RS_STAT = 2'd2,
    RS_CONF = 2'd3
  } reg_sel_e;

  // Meaning of the first payload byte, seen by the IP only.
  typedef enum logic [7:0] {
    PT_RD_REQ  = 8'd1,
    PT_RD_RSP  = 8'd2,
    PT_WR_REQ  = 8'd3,
    PT_WR_RSP  = 8'd4,
    PT_SYNC    = 8'd5
  } pkt_type_e;

endpackage

// File: rtl/ni_fifo.sv
module ni_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/ni_tx_packer.sv
module ni_tx_packer
  import ni_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 3,
  parameter int PRIO_W  = 2,
  parameter int SIZE_W  = 8,
  parameter int VC_W    = 2,
  localparam int HDR_W  = 4*COORD_W + PRIO_W + SIZE_W,
  localparam int FLIT_W = 2 + VC_W + HDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic [DATA_W-1:0] word,
  input  logic              word_avail,
  output logic              word_pop,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [FLIT_W-1:0] tx_flit
);

  localparam int BYTES = DATA_W / 8;
  localparam int BL    = $clog2(BYTES);
  localparam int O_DST = SIZE_W;
  localparam int O_PRI = O_DST + 2*COORD_W;
  localparam int O_VC  = O_PRI + PRIO_W;

  logic                 busy_q, first_q;
  logic [SIZE_W:0]      words_left_q;
  logic [2*COORD_W-1:0] dst_q;
  logic [PRIO_W-1:0]    prio_q;
  logic [SIZE_W-1:0]    size_q;
  logic [VC_W-1:0]      vc_q;

  logic              need_word, last, fire;
  logic [BL-1:0]     rem;
  logic [DATA_W-1:0] data_out;
  logic [HDR_W-1:0]  hdr;
  flit_kind_e        kind;

  assign need_word = (words_left_q != '0);
  assign last      = (words_left_q <= (SIZE_W+1)'(1));
  assign tx_valid  = busy_q && (!need_word || word_avail);
  assign fire      = tx_valid && tx_ready;
  assign word_pop  = (!busy_q && word_avail) || (fire && need_word);
  assign rem       = size_q[BL-1:0];

  always_comb begin
    data_out = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (need_word && (!last || rem == '0 || BL'(b) < rem))
        data_out[8*b +: 8] = word[8*b +: 8];
    end
  end

  always_comb begin
    unique case ({first_q, last})
      2'b11:   kind = FK_SOLO;
      2'b10:   kind = FK_HEAD;
      2'b01:   kind = FK_TAIL;
      default: kind = FK_MID;
    endcase
  end

  assign hdr     = first_q ? {src_x, src_y, dst_q, prio_q, size_q} : '0;
  assign tx_flit = {kind, vc_q, hdr, data_out};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      first_q      <= 1'b0;
      words_left_q <= '0;
      dst_q        <= '0;
      prio_q       <= '0;
      size_q       <= '0;
      vc_q         <= '0;
    end else if (!busy_q && word_avail) begin
      busy_q       <= 1'b1;
      first_q      <= 1'b1;
      size_q       <= word[SIZE_W-1:0];
      dst_q        <= word[O_DST +: 2*COORD_W];
      prio_q       <= word[O_PRI +: PRIO_W];
      vc_q         <= word[O_VC +: VC_W];
      words_left_q <= ({1'b0, word[SIZE_W-1:0]} + (SIZE_W+1)'(BYTES-1)) >> BL;
    end else if (fire) begin
      first_q <= 1'b0;
      if (need_word) words_left_q <= words_left_q - 1'b1;
      if (last)      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ni_rx_unpacker.sv
module ni_rx_unpacker
  import ni_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 3,
  parameter int PRIO_W  = 2,
  parameter int SIZE_W  = 8,
  parameter int VC_W    = 2,
  localparam int HDR_W  = 4*COORD_W + PRIO_W + SIZE_W,
  localparam int FLIT_W = 2 + VC_W + HDR_W + DATA_W,
  localparam int DESC_W = 4*COORD_W + PRIO_W + SIZE_W + VC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              rx_ready,
  input  logic              out_full,
  output logic              push,
  output logic [DATA_W-1:0] push_word,
  output logic              hdr_seen,
  output logic [7:0]        type_byte
);

  logic [DATA_W-1:0]    f_data;
  logic [SIZE_W-1:0]    f_size;
  logic [PRIO_W-1:0]    f_prio;
  logic [2*COORD_W-1:0] f_dst, f_src;
  logic [VC_W-1:0]      f_vc;
  flit_kind_e           f_kind;
  logic [DESC_W-1:0]    desc;

  logic              hold_q;
  logic [DATA_W-1:0] held_q;
  logic [7:0]        type_q;
  logic              fire, is_hdr;

  assign f_data = rx_flit[DATA_W-1:0];
  assign f_size = rx_flit[DATA_W +: SIZE_W];
  assign f_prio = rx_flit[DATA_W+SIZE_W +: PRIO_W];
  assign f_dst  = rx_flit[DATA_W+SIZE_W+PRIO_W +: 2*COORD_W];
  assign f_src  = rx_flit[DATA_W+SIZE_W+PRIO_W+2*COORD_W +: 2*COORD_W];
  assign f_vc   = rx_flit[DATA_W+HDR_W +: VC_W];
  assign f_kind = flit_kind_e'(rx_flit[FLIT_W-1 -: 2]);
  assign desc   = {f_dst, f_vc, f_prio, f_src, f_size};

  assign is_hdr   = (f_kind == FK_HEAD) || (f_kind == FK_SOLO);
  assign rx_ready = !hold_q && !out_full;
  assign fire     = rx_valid && rx_ready;
  assign hdr_seen = fire && is_hdr;
  assign type_byte = type_q;

  always_comb begin
    push      = 1'b0;
    push_word = '0;
    if (hold_q && !out_full) begin
      push      = 1'b1;
      push_word = held_q;
    end else if (fire) begin
      push      = 1'b1;
      push_word = is_hdr ? DATA_W'(desc) : f_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      held_q <= '0;
      type_q <= '0;
    end else begin
      if (hold_q && !out_full) hold_q <= 1'b0;
      if (hdr_seen) begin
        hold_q <= 1'b1;
        held_q <= f_data;
        type_q <= f_data[7:0];
      end
    end
  end

endmodule

// File: rtl/ni_packetizer.sv
module ni_packetizer
  import ni_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int COORD_W    = 3,
  parameter int PRIO_W     = 2,
  parameter int SIZE_W     = 8,
  parameter int VC_W       = 2,
  parameter int ADDR_W     = 4,
  localparam int HDR_W     = 4*COORD_W + PRIO_W + SIZE_W,
  localparam int FLIT_W    = 2 + VC_W + HDR_W + DATA_W,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] node_x,
  input  logic [COORD_W-1:0] node_y,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               suspend,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [FLIT_W-1:0]  tx_flit,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [FLIT_W-1:0]  rx_flit
);

  logic       hit;
  reg_sel_e   sel;
  logic [1:0] cfg_q;
  logic       pending_q;

  logic [DATA_W-1:0] in_head, out_head, rx_word;
  logic [CNT_W-1:0]  in_cnt, out_cnt;
  logic in_full, in_empty, in_pop;
  logic out_full, out_empty, out_push;
  logic hdr_seen;
  logic [7:0] type_byte;
  logic [15:0] status;

  assign hit = (reg_addr[1:0] == 2'b00);
  assign sel = reg_sel_e'(reg_addr[3:2]);

  ni_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_q (
    .clk(clk), .rst_n(rst_n),
    .push(reg_wr && hit && sel == RS_TXQ), .din(reg_wdata),
    .pop(in_pop), .dout(in_head),
    .count(in_cnt), .full(in_full), .empty(in_empty)
  );

  ni_tx_packer #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .PRIO_W(PRIO_W),
    .SIZE_W(SIZE_W), .VC_W(VC_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .src_x(node_x), .src_y(node_y),
    .word(in_head), .word_avail(!in_empty), .word_pop(in_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit)
  );

  ni_rx_unpacker #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .PRIO_W(PRIO_W),
    .SIZE_W(SIZE_W), .VC_W(VC_W)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flit(rx_flit),
    .rx_ready(rx_ready), .out_full(out_full), .push(out_push),
    .push_word(rx_word), .hdr_seen(hdr_seen), .type_byte(type_byte)
  );

  ni_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_q (
    .clk(clk), .rst_n(rst_n),
    .push(out_push), .din(rx_word),
    .pop(reg_rd && hit && sel == RS_RXQ), .dout(out_head),
    .count(out_cnt), .full(out_full), .empty(out_empty)
  );

  assign status = {type_byte, 3'b000, pending_q, out_empty, out_full, in_empty, in_full};

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      unique case (sel)
        RS_RXQ:  reg_rdata = out_empty ? '0 : out_head;
        RS_STAT: reg_rdata = DATA_W'(status);
        RS_CONF: reg_rdata = DATA_W'(cfg_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      if (reg_wr && hit && sel == RS_CONF) cfg_q <= reg_wdata[1:0];
      if (hdr_seen)                             pending_q <= 1'b1;
      else if (reg_wr && hit && sel == RS_STAT) pending_q <= 1'b0;
    end
  end

  assign irq     = cfg_q[0] && pending_q;
  assign suspend = cfg_q[1] && in_full;

endmodule

// File: rtl/ni_packetizer_chk.sv
module ni_packetizer_chk #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int FLIT_W     = 58,
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [FLIT_W-1:0] tx_flit,
  input logic              rx_ready,
  input logic              irq,
  input logic              suspend,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [1:0]        cfg_q,
  input logic [CNT_W-1:0]  in_cnt,
  input logic [CNT_W-1:0]  out_cnt
);

  logic       in_pkt_q;
  logic       tx_fire;
  logic [1:0] kind;

  assign tx_fire = tx_valid && tx_ready;
  assign kind    = tx_flit[FLIT_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n)                        in_pkt_q <= 1'b0;
    else if (tx_fire && kind == 2'b01) in_pkt_q <= 1'b1;
    else if (tx_fire && kind == 2'b10) in_pkt_q <= 1'b0;
  end

  // R3: inside a packet only middle or last flits may follow
  p_inside_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && in_pkt_q) |-> (kind == 2'b00 || kind == 2'b10));

  // R3: a packet must open with a header or a combined flit
  p_opening_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !in_pkt_q) |-> (kind == 2'b01 || kind == 2'b11));

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CNT_W'(FIFO_DEPTH)) && (out_cnt <= CNT_W'(FIFO_DEPTH)));

  p_suspend_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (cfg_q[1] && in_cnt == CNT_W'(FIFO_DEPTH)));

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(4) && out_cnt == '0) |-> (reg_rdata == '0));

  p_rx_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (out_cnt < CNT_W'(FIFO_DEPTH)));

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_q[0]);

endmodule

bind ni_packetizer ni_packetizer_chk #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .FLIT_W(FLIT_W),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_flit(tx_flit), .rx_ready(rx_ready), .irq(irq), .suspend(suspend),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cfg_q(cfg_q), .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/test_ni_packetizer.sv
module test_ni_packetizer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, suspend;
  logic        tx_valid, tx_ready;
  logic [57:0] tx_flit;
  logic        rx_valid, rx_ready;
  logic [57:0] rx_flit;

  always #5 clk = ~clk;

  ni_packetizer i_ni_packetizer (
    .clk(clk), .rst_n(rst_n), .node_x(3'd1), .node_y(3'd2),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .suspend(suspend),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit)
  );

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit tx_hold = 1'b0;
  bit done = 1'b0;
  logic [57:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] pw[16];
  logic [31:0] v;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Scoreboard driver: expected flits from size, source and descriptor fields
  task automatic exp_pkt(input logic [2:0] dx, input logic [2:0] dy, input logic [1:0] pr,
                         input logic [1:0] vc, input int size);
    int nw = (size + 3) / 4;
    int nf = (nw == 0) ? 1 : nw;
    for (int f = 0; f < nf; f++) begin
      logic [1:0]  k;
      logic [21:0] h;
      logic [31:0] d;
      string t;
      if (nf == 1)          begin k = 2'b11; t = "R2 single flit"; end
      else if (f == 0)      begin k = 2'b01; t = "R3 head flit"; end
      else if (f == nf - 1) begin k = 2'b10; t = "R3 tail flit"; end
      else                  begin k = 2'b00; t = "R3 middle flit"; end
      h = (f == 0) ? {3'd1, 3'd2, dx, dy, pr, 8'(size)} : 22'd0;
      d = (nw == 0) ? 32'd0 : pw[f];
      if (f == nf - 1 && (size % 4) != 0) begin
        for (int b = 0; b < 4; b++)
          if (b >= size % 4) d[8*b +: 8] = 8'h00;
        t = {t, " R5 padded"};
      end
      exp_q.push_back({k, vc, h, d});
      tag_q.push_back({t, " R4 fields"});
    end
  endtask

  function automatic logic [31:0] desc(input logic [2:0] dx, input logic [2:0] dy,
                                       input logic [1:0] pr, input logic [1:0] vc, input int size);
    return {14'd0, vc, pr, dx, dy, 8'(size)};
  endfunction

  task automatic send_pkt(input logic [2:0] dx, input logic [2:0] dy, input logic [1:0] pr,
                          input logic [1:0] vc, input int size);
    exp_pkt(dx, dy, pr, vc, size);
    wr(4'h0, desc(dx, dy, pr, vc, size));
    for (int i = 0; i < (size + 3) / 4; i++) wr(4'h0, pw[i]);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R3 all expected flits emitted", 64'(exp_q.size()), 64'd0);
  endtask

  function automatic logic [57:0] rxf(input logic [1:0] k, input logic [1:0] vc,
                                      input logic [2:0] sx, input logic [2:0] sy,
                                      input logic [1:0] pr, input logic [7:0] sz,
                                      input logic [31:0] d);
    return {k, vc, sx, sy, 6'd0, pr, sz, d};
  endfunction

  task automatic send_rx(input logic [57:0] f);
    rx_flit = f; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Monitor: drives ready, compares every accepted flit with the scoreboard
  initial begin
    logic [57:0] prev_flit;
    bit was_stall;
    prev_flit = '0;
    was_stall = 1'b0;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n || done) begin
        tx_ready = 1'b0;
        was_stall = 1'b0;
      end else begin
        tx_ready = !tx_hold && (cyc % 3 != 1);
        #1;
        if (was_stall) chk("R6 stalled flit held", {5'd0, tx_valid, tx_flit}, {5'd0, 1'b1, prev_flit});
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) begin
            chk("R3 unexpected flit", {6'd0, tx_flit}, 64'd0);
            if (tx_flit == '0) begin errs++; $display("FAIL R3 unexpected flit actual=0 expected=none"); end
          end else begin
            logic [57:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {6'd0, tx_flit}, {6'd0, e});
          end
        end
        was_stall = tx_valid && !tx_ready;
        prev_flit = tx_flit;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    rx_valid = 1'b0; rx_flit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(4'h8, v);  chk("R13 status after reset", 64'(v), 64'h0A);
    chk("R12 irq after reset", 64'(irq), 64'd0);
    chk("R8 suspend after reset", 64'(suspend), 64'd0);
    chk("R3 no flit after reset", 64'(tx_valid), 64'd0);
    wr(4'hC, 32'd3);
    rd(4'hC, v);  chk("R1 config readback", 64'(v), 64'd3);
    rd(4'h0, v);  chk("R1 input address reads zero", 64'(v), 64'd0);
    rd(4'hD, v);  chk("R1 unaligned address reads zero", 64'(v), 64'd0);

    // Transmit patterns
    pw[0] = 32'hAABBCCDD;
    send_pkt(3'd3, 3'd2, 2'd1, 2'd2, 3);
    pw[0] = 32'h11111111; pw[1] = 32'h22222222; pw[2] = 32'h33333333;
    send_pkt(3'd0, 3'd1, 2'd2, 2'd1, 10);
    send_pkt(3'd4, 3'd1, 2'd0, 2'd0, 0);
    pw[0] = 32'h5A5A0001; pw[1] = 32'h5A5A0002;
    send_pkt(3'd2, 3'd3, 2'd3, 2'd3, 8);
    pw[0] = 32'h01020304;
    send_pkt(3'd1, 3'd0, 2'd0, 2'd1, 4);
    drain();

    // Full input queue, suspend and dropped write
    tx_hold = 1'b1;
    for (int k = 0; k < 9; k++) pw[k] = 32'hC0DE0000 + k;
    exp_pkt(3'd1, 3'd1, 2'd0, 2'd1, 36);
    wr(4'h0, desc(3'd1, 3'd1, 2'd0, 2'd1, 36));
    repeat (4) @(negedge clk);
    chk("R8 no suspend before full", 64'(suspend), 64'd0);
    for (int k = 0; k < 8; k++) wr(4'h0, pw[k]);
    rd(4'h8, v);  chk("R13 status with input full", 64'(v), 64'h09);
    chk("R8 suspend when full", 64'(suspend), 64'd1);
    wr(4'h0, 32'hDEADBEEF);
    rd(4'h8, v);  chk("R7 still full after dropped write", 64'(v), 64'h09);
    wr(4'hC, 32'd1);
    chk("R8 suspend gated by config", 64'(suspend), 64'd0);
    wr(4'hC, 32'd3);
    chk("R8 suspend re-enabled", 64'(suspend), 64'd1);
    tx_hold = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8 suspend drops after drain", 64'(suspend), 64'd0);
    wr(4'h0, pw[8]);
    drain();

    // Receive single flit packet with interrupt enabled
    wr(4'hC, 32'd1);
    chk("R12 irq idle", 64'(irq), 64'd0);
    send_rx(rxf(2'b11, 2'd1, 3'd2, 3'd1, 2'd3, 8'd2, 32'h0000AB05));
    repeat (2) @(negedge clk);
    chk("R12 irq on arrival", 64'(irq), 64'd1);
    rd(4'h8, v);  chk("R13 status after arrival", 64'(v), 64'h0512);
    rd(4'h4, v);  chk("R9 descriptor word", 64'(v), 64'h0001D102);
    rd(4'h4, v);  chk("R9 data word", 64'(v), 64'h0000AB05);
    rd(4'h4, v);  chk("R10 empty read returns zero", 64'(v), 64'd0);
    rd(4'h8, v);  chk("R13 status output empty", 64'(v), 64'h051A);
    wr(4'h8, 32'd0);
    chk("R12 irq cleared", 64'(irq), 64'd0);
    rd(4'h8, v);  chk("R12 flag cleared in status", 64'(v), 64'h050A);

    // Arrival with interrupt disabled
    wr(4'hC, 32'd0);
    send_rx(rxf(2'b11, 2'd0, 3'd0, 3'd0, 2'd0, 8'd4, 32'h77665503));
    repeat (2) @(negedge clk);
    chk("R12 irq masked", 64'(irq), 64'd0);
    rd(4'h8, v);  chk("R13 type byte and flag", 64'(v), 64'h0312);
    rd(4'h4, v);  chk("R10 no underflow, descriptor next", 64'(v), 64'h00000004);
    rd(4'h4, v);  chk("R9 data after descriptor", 64'(v), 64'h77665503);

    // Multi-flit receive filling the output queue
    send_rx(rxf(2'b01, 2'd2, 3'd0, 3'd2, 2'd1, 8'd28, 32'hD0000000));
    for (int k = 1; k <= 6; k++) send_rx(rxf(2'b00, 2'd2, 3'd0, 3'd0, 2'd0, 8'd0, 32'hD0000000 + k));
    repeat (2) @(negedge clk);
    rd(4'h8, v);  chk("R13 status output full", 64'(v), 64'h0016);
    fork
      send_rx(rxf(2'b10, 2'd2, 3'd0, 3'd0, 2'd0, 8'd0, 32'hD0000007));
      begin
        repeat (3) @(negedge clk);
        chk("R11 ready low while full", 64'(rx_ready), 64'd0);
        rd(4'h4, v);  chk("R9 head descriptor", 64'(v), 64'h0002421C);
        for (int k = 0; k < 8; k++) begin
          rd(4'h4, v);
          chk("R9 payload order", 64'(v), 64'(32'hD0000000 + k));
        end
      end
    join
    rd(4'h4, v);  chk("R10 empty after drain", 64'(v), 64'd0);
    chk("R3 no stray flit", 64'(tx_valid), 64'd0);

    done = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule